// File: doc/BRIEF.md
# Serial RAM Loader Controller

This block brings up a processor's working memory from an 8N1 asynchronous serial line, with no software involved. Two strap inputs are read once after reset and select one of three modes.

In load mode the first received byte gives the length of the whole message, and that length counts the length byte itself. The remaining bytes are written one by one into RAM at consecutive addresses, starting one above the RAM base. After the last byte is written, a single-cycle start pulse carries the entry address to the processor. In execute mode the start pulse fires at once, so code already held in RAM runs without a new download. In test mode the block sweeps a ROM region and presents each byte on an 8-bit parallel port for a chosen number of cycles, wrapping at the end of the region.

A byte that completes while the previous one is still unconsumed pulls an active-low overrun flag. Only a reset releases that flag. The controller states are `LD_MODE` (decode the straps), `LD_COUNT` (wait for the length byte), `LD_PAYLOAD` (write payload bytes), `LD_START` (issue the start pulse), `LD_DONE` (idle until reset) and `LD_TEST` (stream the ROM). The transitions are:
- `LD_MODE` goes to `LD_TEST`, `LD_COUNT` or `LD_START`, according to the straps.
- `LD_COUNT` goes to `LD_START` when the length is 0 or 1, and to `LD_PAYLOAD` otherwise.
- `LD_PAYLOAD` goes to `LD_START` after the last payload byte.
- `LD_START` always goes to `LD_DONE`.

The receiver runs its own cycle: `RX_IDLE`, `RX_START` (start-bit check at mid-bit), `RX_BITS`, `RX_STOP`, and back to `RX_IDLE`.

Top module: `serial_ram_loader`

## Requirements
- R1: The receiver takes 8N1 frames, least significant data bit first, with a bit period of CLK_HZ/BAUD cycles, sampled at 16 ticks per bit near the middle of each bit.
- R2: A low pulse on the serial input that is shorter than half a bit period is rejected at the mid-start check and produces no byte.
- R3: A frame whose stop bit samples as 0 is discarded and has no effect on the packet being loaded.
- R4: In load mode the first byte is COUNT, which includes itself. The next COUNT-1 bytes are written to RAM addresses RAM_BASE+1, RAM_BASE+2, and so on upward. Each write is one cycle of `ram_we` with the address and the data valid in that cycle.
- R5: `exec_go` is a one-cycle pulse, asserted in the cycle right after the last payload write strobe. While it is high, `exec_addr` equals RAM_BASE+1 (0x0051 by default); otherwise `exec_addr` is 0.
- R6: A COUNT of 0 or 1 causes no RAM writes and leads straight to the `exec_go` pulse.
- R7: If fewer than COUNT bytes arrive, the block keeps waiting indefinitely: it gives no `exec_go` and has no timeout.
- R8: The straps are decoded in the first cycle after reset. `strap_a`=0 selects test mode whatever `strap_b` is. `strap_a`=1 with `strap_b`=1 selects load mode. `strap_a`=1 with `strap_b`=0 selects execute mode, which gives one `exec_go` with no serial input and no writes.
- R9: In test mode `port_out` shows ROM bytes in address order from ROM_BASE. Each byte is held for `test_hold` cycles, with 0 treated as 1. The address wraps to ROM_BASE after ROM_BASE+ROM_LEN-1. RAM is never written in this mode.
- R10: `overrun_n` is 1 after reset. It goes to 0 when a byte completes while the previous byte is still unconsumed, and it stays 0 until reset. Bytes are consumed only while the block is waiting for the length byte or for payload bytes.
- R11: Outside test mode `port_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| strap_a | input | 1 | Mode strap: 0 selects test mode |
| strap_b | input | 1 | Mode strap: load (1) or execute (0), used when strap_a is 1 |
| test_hold | input | HOLD_W | Cycles each ROM byte is held in test mode (0 treated as 1) |
| rom_rdata | input | 8 | ROM read data for rom_addr (combinational read) |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| rom_addr | output | ADDR_W | ROM read address |
| port_out | output | 8 | Parallel output port |
| overrun_n | output | 1 | Sticky active-low overrun flag |
| exec_go | output | 1 | Start-execution pulse |
| exec_addr | output | ADDR_W | Entry address, valid with exec_go |

## Verification
The hardest situation to reach is an overrun. The controller consumes every byte in the cycle it arrives while loading, so an overrun cannot arise during a download. The bench reaches it by selecting test mode, where nothing consumes received bytes, and sending two full frames back to back. It then checks that one pending byte alone does not lower the flag, that two do, and that only a reset raises it again. Rejected frames are reached by driving a deliberately short low glitch and a frame with a zero stop bit ahead of a valid packet. The resulting RAM image then shows whether either was mistaken for the length byte.

// File: rtl/loader_pkg.sv
package loader_pkg;

    typedef enum logic [2:0] {
        LD_MODE,
        LD_COUNT,
        LD_PAYLOAD,
        LD_START,
        LD_DONE,
        LD_TEST
    } ld_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/uart_rx16.sv
module uart_rx16 #(
    parameter int unsigned OS_DIV = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in,
    input  logic       consume,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       overrun_evt
);
    import loader_pkg::*;

    localparam int unsigned DIV_W = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OS_DIV - 1);

    rx_state_t        rx_state, rx_next;
    logic [1:0]       sync_q;
    logic             rx_s;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic [3:0]       os_q;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;
    logic             mid_start, bit_end;

    assign rx_s      = sync_q[1];
    assign tick      = (div_q == DIV_LAST);
    assign mid_start = tick && (os_q == 4'd7);
    assign bit_end   = tick && (os_q == 4'd15);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_state <= RX_IDLE;
        else        rx_state <= rx_next;
    end

    always_comb begin
        rx_next = rx_state;
        unique case (rx_state)
            RX_IDLE:  if (!rx_s) rx_next = RX_START;
            RX_START: if (mid_start) rx_next = rx_s ? RX_IDLE : RX_BITS;
            RX_BITS:  if (bit_end && bit_idx == 3'd7) rx_next = RX_STOP;
            RX_STOP:  if (bit_end) rx_next = RX_IDLE;
            default:  rx_next = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q      <= 2'b11;
            div_q       <= '0;
            os_q        <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            byte_valid  <= 1'b0;
            byte_data   <= '0;
            overrun_evt <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rx_in};
            if (rx_state == RX_IDLE) begin
                div_q   <= '0;
                os_q    <= '0;
                bit_idx <= '0;
            end else begin
                div_q <= tick ? '0 : div_q + DIV_W'(1);
                if (tick)
                    os_q <= (rx_state == RX_START && os_q == 4'd7) ? 4'd0 : os_q + 4'd1;
            end
            if (rx_state == RX_BITS && bit_end) begin
                shreg   <= {rx_s, shreg[7:1]};
                bit_idx <= bit_idx + 3'd1;
            end
            if (rx_state == RX_STOP && bit_end && rx_s) begin
                byte_valid  <= 1'b1;
                byte_data   <= shreg;
                overrun_evt <= byte_valid && !consume;
            end else begin
                overrun_evt <= 1'b0;
                if (consume) byte_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rom_streamer.sv
module rom_streamer #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned ROM_BASE = 'h0100,
    parameter int unsigned ROM_LEN  = 240,
    parameter int unsigned HOLD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HOLD_W-1:0] hold,
    input  logic [7:0]        rom_rdata,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [7:0]        port_out
);
    localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(ROM_BASE);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(ROM_BASE + ROM_LEN - 1);

    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] hold_last;

    assign hold_last = (hold == '0) ? '0 : hold - HOLD_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_addr <= FIRST;
            cnt_q    <= '0;
            port_out <= '0;
        end else if (en) begin
            port_out <= rom_rdata;
            if (cnt_q >= hold_last) begin
                cnt_q    <= '0;
                rom_addr <= (rom_addr == LAST) ? FIRST : rom_addr + ADDR_W'(1);
            end else begin
                cnt_q <= cnt_q + HOLD_W'(1);
            end
        end
    end

endmodule

// File: rtl/serial_ram_loader.sv
module serial_ram_loader #(
    parameter int unsigned CLK_HZ   = 2_000_000,
    parameter int unsigned BAUD     = 9600,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned RAM_BASE = 'h0050,
    parameter int unsigned ROM_BASE = 'h0100,
    parameter int unsigned ROM_LEN  = 240,
    parameter int unsigned HOLD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              strap_a,
    input  logic              strap_b,
    input  logic [HOLD_W-1:0] test_hold,
    input  logic [7:0]        rom_rdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [7:0]        port_out,
    output logic              overrun_n,
    output logic              exec_go,
    output logic [ADDR_W-1:0] exec_addr
);
    import loader_pkg::*;

    localparam int unsigned OS_DIV_RAW = CLK_HZ / (BAUD * 16);
    localparam int unsigned OS_DIV     = (OS_DIV_RAW < 1) ? 1 : OS_DIV_RAW;
    localparam logic [ADDR_W-1:0] ENTRY = ADDR_W'(RAM_BASE + 1);

    ld_state_t         state, state_next;
    logic              byte_valid, consume, overrun_evt;
    logic [7:0]        byte_data;
    logic [7:0]        remaining;
    logic [ADDR_W-1:0] wr_ptr;

    assign consume = byte_valid && (state == LD_COUNT || state == LD_PAYLOAD);

    uart_rx16 #(.OS_DIV(OS_DIV)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_in       (rx_in),
        .consume     (consume),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .overrun_evt (overrun_evt)
    );

    rom_streamer #(
        .ADDR_W   (ADDR_W),
        .ROM_BASE (ROM_BASE),
        .ROM_LEN  (ROM_LEN),
        .HOLD_W   (HOLD_W)
    ) u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state == LD_TEST),
        .hold      (test_hold),
        .rom_rdata (rom_rdata),
        .rom_addr  (rom_addr),
        .port_out  (port_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_MODE;
        else        state <= state_next;
    end

    always_comb begin
        state_next = state;
        unique case (state)
            LD_MODE: begin
                if (!strap_a)     state_next = LD_TEST;
                else if (strap_b) state_next = LD_COUNT;
                else              state_next = LD_START;
            end
            LD_COUNT:
                if (byte_valid)
                    state_next = (byte_data <= 8'd1) ? LD_START : LD_PAYLOAD;
            LD_PAYLOAD:
                if (byte_valid && remaining == 8'd1) state_next = LD_START;
            LD_START: state_next = LD_DONE;
            LD_DONE:  state_next = LD_DONE;
            LD_TEST:  state_next = LD_TEST;
            default:  state_next = LD_MODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
            remaining <= '0;
            wr_ptr    <= ENTRY;
            overrun_n <= 1'b1;
            exec_go   <= 1'b0;
            exec_addr <= '0;
        end else begin
            ram_we    <= 1'b0;
            overrun_n <= overrun_n & ~overrun_evt;
            exec_go   <= (state == LD_START);
            exec_addr <= (state == LD_START) ? ENTRY : '0;
            if (state == LD_COUNT && byte_valid) begin
                remaining <= byte_data - 8'd1;
                wr_ptr    <= ENTRY;
            end
            if (state == LD_PAYLOAD && byte_valid) begin
                ram_we    <= 1'b1;
                ram_addr  <= wr_ptr;
                ram_wdata <= byte_data;
                wr_ptr    <= wr_ptr + ADDR_W'(1);
                remaining <= remaining - 8'd1;
            end
        end
    end

endmodule

// File: rtl/loader_chk.sv
module loader_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned RAM_BASE = 'h0050
) (
    input logic                  clk,
    input logic                  rst_n,
    input loader_pkg::ld_state_t state,
    input logic                  ram_we,
    input logic [ADDR_W-1:0]     ram_addr,
    input logic                  overrun_n,
    input logic                  exec_go,
    input logic [ADDR_W-1:0]     exec_addr
);
    // R5
    exec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |=> !exec_go);

    // R5
    exec_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |-> (exec_addr == ADDR_W'(RAM_BASE + 1)));

    // R5
    exec_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |-> !ram_we);

    // R4
    ram_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr > ADDR_W'(RAM_BASE)));

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !overrun_n |=> !overrun_n);

    // R9
    test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == loader_pkg::LD_TEST) |-> !ram_we);

endmodule

bind serial_ram_loader loader_chk #(
    .ADDR_W   (ADDR_W),
    .RAM_BASE (RAM_BASE)
) u_loader_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .overrun_n (overrun_n),
    .exec_go   (exec_go),
    .exec_addr (exec_addr)
);

// File: tb/tb_serial_ram_loader.sv
module tb_serial_ram_loader;
    localparam int unsigned CLK_HZ   = 1_600_000;
    localparam int unsigned BAUD     = 10_000;
    localparam int          BITC     = CLK_HZ / BAUD;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned RAM_BASE = 'h0050;
    localparam int unsigned ROM_BASE = 'h0100;
    localparam int unsigned ROM_LEN  = 4;
    localparam int unsigned HOLD_W   = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0, rx_in = 1'b1, strap_a = 1'b1, strap_b = 1'b1;
    logic [HOLD_W-1:0] test_hold = '0;
    logic [7:0]        rom_rdata, ram_wdata, port_out;
    logic              ram_we, overrun_n, exec_go;
    logic [ADDR_W-1:0] ram_addr, rom_addr, exec_addr;

    function automatic logic [7:0] rom_fn(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign rom_rdata = rom_fn(rom_addr);

    serial_ram_loader #(
        .CLK_HZ(CLK_HZ), .BAUD(BAUD), .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE),
        .ROM_BASE(ROM_BASE), .ROM_LEN(ROM_LEN), .HOLD_W(HOLD_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .strap_a(strap_a), .strap_b(strap_b),
        .test_hold(test_hold), .rom_rdata(rom_rdata), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rom_addr(rom_addr),
        .port_out(port_out), .overrun_n(overrun_n), .exec_go(exec_go),
        .exec_addr(exec_addr)
    );

    int checks = 0, failures = 0;

    // monitor of the RAM port and the start pulse
    logic       mon_clr = 1'b0;
    logic [7:0] wmem [0:255];
    int         nwrites, nexec, cyc, last_w_cyc, exec_cyc;
    logic [ADDR_W-1:0] exec_seen;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
            nwrites = 0; nexec = 0; last_w_cyc = -10; exec_cyc = -20; exec_seen = '0;
        end else begin
            if (ram_we) begin
                wmem[ram_addr[7:0]] = ram_wdata;
                nwrites = nwrites + 1;
                last_w_cyc = cyc;
            end
            if (exec_go) begin
                nexec = nexec + 1;
                exec_cyc = cyc;
                exec_seen = exec_addr;
            end
        end
    end

    initial cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic a, input logic b, input logic [HOLD_W-1:0] h);
        rst_n = 1'b0; rx_in = 1'b1; strap_a = a; strap_b = b; test_hold = h;
        mon_clr = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic stop);
        rx_in = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            repeat (BITC) @(negedge clk);
        end
        rx_in = stop;
        repeat (BITC) @(negedge clk);
        rx_in = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic t_reset_state;
        do_reset(1'b1, 1'b1, 0);
        chk(overrun_n === 1'b1, "R10 overrun_n after reset", {31'd0, overrun_n}, 1);
        chk(exec_go === 1'b0 && ram_we === 1'b0, "R4 no strobes after reset", {30'd0, exec_go, ram_we}, 0);
        chk(port_out === 8'h00, "R11 port idle after reset", {24'd0, port_out}, 0);
    endtask

    task automatic t_load_normal;
        do_reset(1'b1, 1'b1, 0);
        send_byte(8'd4, 1'b1);
        send_byte(8'h11, 1'b1);
        send_byte(8'hC3, 1'b1);
        send_byte(8'h5A, 1'b1);
        repeat (50) @(negedge clk);
        chk(nwrites == 3, "R4 write count", nwrites, 3);
        chk(wmem[8'h51] == 8'h11, "R1 R4 byte at base+1", {24'd0, wmem[8'h51]}, 32'h11);
        chk(wmem[8'h52] == 8'hC3, "R1 R4 byte at base+2", {24'd0, wmem[8'h52]}, 32'hC3);
        chk(wmem[8'h53] == 8'h5A, "R4 byte at base+3", {24'd0, wmem[8'h53]}, 32'h5A);
        chk(wmem[8'h50] == 8'h00, "R4 base not written", {24'd0, wmem[8'h50]}, 0);
        chk(nexec == 1, "R5 one start pulse", nexec, 1);
        chk(exec_seen == 16'h0051, "R5 entry address", exec_seen, 32'h51);
        chk(exec_cyc == last_w_cyc + 1, "R5 pulse right after last write", exec_cyc, last_w_cyc + 1);
        chk(exec_addr == '0, "R5 entry address zero outside pulse", exec_addr, 0);
        chk(overrun_n === 1'b1, "R10 no overrun in clean load", {31'd0, overrun_n}, 1);
        chk(port_out === 8'h00, "R11 port idle in load mode", {24'd0, port_out}, 0);
    endtask

    task automatic t_short_count(input logic [7:0] c);
        do_reset(1'b1, 1'b1, 0);
        send_byte(c, 1'b1);
        repeat (50) @(negedge clk);
        chk(nwrites == 0, "R6 no writes for tiny count", nwrites, 0);
        chk(nexec == 1, "R6 start pulse for tiny count", nexec, 1);
    endtask

    task automatic t_partial;
        do_reset(1'b1, 1'b1, 0);
        send_byte(8'd5, 1'b1);
        send_byte(8'hAB, 1'b1);
        send_byte(8'hCD, 1'b1);
        repeat (3000) @(negedge clk);
        chk(nwrites == 2, "R7 partial writes", nwrites, 2);
        chk(nexec == 0, "R7 no start on short packet", nexec, 0);
    endtask

    task automatic t_glitch;
        do_reset(1'b1, 1'b1, 0);
        rx_in = 1'b0;
        repeat (BITC / 5) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * BITC) @(negedge clk);
        send_byte(8'd2, 1'b1);
        send_byte(8'h5C, 1'b1);
        repeat (50) @(negedge clk);
        chk(nwrites == 1 && wmem[8'h51] == 8'h5C, "R2 glitch ignored", {24'd0, wmem[8'h51]}, 32'h5C);
        chk(nexec == 1, "R2 packet completes after glitch", nexec, 1);
    endtask

    task automatic t_bad_stop;
        do_reset(1'b1, 1'b1, 0);
        send_byte(8'd3, 1'b0);
        send_byte(8'd3, 1'b1);
        send_byte(8'hAA, 1'b1);
        send_byte(8'hBB, 1'b1);
        repeat (50) @(negedge clk);
        chk(wmem[8'h51] == 8'hAA, "R3 bad frame dropped, first payload", {24'd0, wmem[8'h51]}, 32'hAA);
        chk(wmem[8'h52] == 8'hBB, "R3 bad frame dropped, second payload", {24'd0, wmem[8'h52]}, 32'hBB);
        chk(nwrites == 2, "R3 write count", nwrites, 2);
    endtask

    task automatic t_exec_mode;
        do_reset(1'b1, 1'b0, 0);
        repeat (20) @(negedge clk);
        chk(nexec == 1, "R8 execute mode pulse", nexec, 1);
        chk(exec_seen == 16'h0051, "R8 execute mode entry", exec_seen, 32'h51);
        chk(nwrites == 0, "R8 execute mode no writes", nwrites, 0);
    endtask

    task automatic t_test_mode(input logic b, input logic [HOLD_W-1:0] h);
        int hold_eff;
        int waited;
        bit ok;
        hold_eff = (h == 0) ? 1 : int'(h);
        do_reset(1'b0, b, h);
        waited = 0;
        while (port_out !== rom_fn(ADDR_W'(ROM_BASE)) && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 20, "R8 test mode selected", waited, 0);
        for (int k = 0; k < 2 * int'(ROM_LEN) + 1; k++) begin
            logic [7:0] expv;
            ok = 1'b1;
            expv = rom_fn(ADDR_W'(ROM_BASE + (k % ROM_LEN)));
            for (int j = 0; j < hold_eff; j++) begin
                if (port_out !== expv) ok = 1'b0;
                @(negedge clk);
            end
            chk(ok, "R9 ROM byte run", {24'd0, port_out}, {24'd0, expv});
        end
        chk(nwrites == 0 && nexec == 0, "R9 no writes or start in test mode", nwrites + nexec, 0);
    endtask

    task automatic t_overrun;
        do_reset(1'b0, 1'b1, 1);
        send_byte(8'h33, 1'b1);
        repeat (20) @(negedge clk);
        chk(overrun_n === 1'b1, "R10 single pending byte no overrun", {31'd0, overrun_n}, 1);
        send_byte(8'h44, 1'b1);
        repeat (20) @(negedge clk);
        chk(overrun_n === 1'b0, "R10 overrun flagged", {31'd0, overrun_n}, 0);
        repeat (500) @(negedge clk);
        chk(overrun_n === 1'b0, "R10 overrun sticky", {31'd0, overrun_n}, 0);
        do_reset(1'b1, 1'b1, 0);
        chk(overrun_n === 1'b1, "R10 overrun cleared by reset", {31'd0, overrun_n}, 1);
    endtask

    initial begin
        t_reset_state();
        t_load_normal();
        t_short_count(8'd1);
        t_short_count(8'd0);
        t_partial();
        t_glitch();
        t_bad_stop();
        t_exec_mode();
        t_test_mode(1'b1, 3);
        t_test_mode(1'b0, 0);
        t_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule